// File: doc/BRIEF.md
# External Interrupt Sense Unit with Noise Filter

This unit watches four asynchronous interrupt pins and turns their activity into pending requests for a processor core. Each pin is brought into the clock domain through a two-stage synchronizer. The first two inputs can be armed for a rising edge, a falling edge, a high level or a low level. The upper two inputs can be armed for a rising edge, a falling edge or both edges. Input 3 also passes through a digital noise filter. The filter samples either every cycle or once every sixteen cycles, and it accepts a new level only after two consecutive samples agree.

Edge-armed requests stay latched until software clears them with an acknowledge bit. Level-armed requests track the pin while the input is enabled. The highest-priority enabled request is presented as an index and as a fixed vector address. Inputs 2 and 3 also send a one-cycle event pulse to an external timer on every qualifying edge. These pulses do not depend on the interrupt enables.

Top module: `extIrqSense`

## Requirements
- R1: When a request is active, `irqVector` is 03h for input 0, 0Bh for input 1, 13h for input 2 and 1Bh for input 3, and `irqId` holds the input number. With no request, both outputs are zero.
- R2: When several enabled inputs are pending at once, the lowest input number wins: input 0 has the highest priority and input 3 the lowest.
- R3: Each input uses the 2-bit field `modeCfg[2i+1:2i]`. On inputs 0 and 1, code 00 latches a rising edge and code 01 latches a falling edge. A latched edge flag stays set until the matching `ack` bit is pulsed, and that pulse clears it.
- R4: On inputs 0 and 1, code 10 makes the pending flag follow a high pin level and code 11 makes it follow a low pin level, while the input is enabled. An `ack` pulse has no effect on a level-armed flag.
- R5: On inputs 2 and 3, code 00 latches a rising edge, code 01 latches a falling edge, and codes 10 and 11 latch both edges. No level mode exists on these inputs.
- R6: An event on an input whose `enable` bit is 0 is not latched, and that input never raises `irqReq`.
- R7: With `filtSlow` = 0, input 3 ignores a pulse that lasts 1 clock cycle and accepts a pulse that lasts 2 cycles or more.
- R8: With `filtSlow` = 1, input 3 samples once every 16 cycles. It ignores a pulse shorter than 16 cycles and accepts a pulse of 32 cycles or more.
- R9: `tmrEvent[0]` (input 2) and `tmrEvent[1]` (input 3) each pulse for exactly one cycle on every edge that the input's mode qualifies, whatever the `enable` bits are.
- R10: After reset, no flag is pending, `irqReq` is 0, `irqVector` is 0 and `tmrEvent` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 4 | Asynchronous interrupt pins, bit i is input i |
| modeCfg | input | 8 | Per-input 2-bit trigger mode code |
| filtSlow | input | 1 | Sample rate of the input 3 filter: 0 = every cycle, 1 = every 16 cycles |
| enable | input | 4 | Per-input interrupt enable |
| ack | input | 4 | Per-input pulse that clears a latched edge flag |
| irqReq | output | 1 | An enabled request is pending |
| irqId | output | 2 | Index of the winning input |
| irqVector | output | 8 | Vector address of the winning input |
| pendFlags | output | 4 | Raw pending flags |
| tmrEvent | output | 2 | Timer count pulses for inputs 2 and 3 |

## Verification
A stimulus table drives each input's pin through one transition under every mode code. Rising versus falling transitions separate the two single-edge codes. Repeating a pin level separates level tracking from edge latching. Masked enables show that events are not latched.

Directed tests then:
- walk the acknowledges down a fully pending set, which shows the priority order and each vector;
- feed input 3 pulses just below and just above the filter threshold at both sample rates;
- toggle inputs 2 and 3 with interrupts disabled, so that the count of event pulses tells both-edge mode apart from single-edge mode.

// File: rtl/extIrqPkg.sv
package extIrqPkg;
  localparam int NUM_IRQ = 4;

  typedef enum logic [1:0] {
    MODE_RISE = 2'b00,
    MODE_FALL = 2'b01,
    MODE_HIGH = 2'b10,
    MODE_LOW  = 2'b11
  } irqMode_e;

  typedef struct packed {
    logic [NUM_IRQ-1:0] setPend;
    logic [NUM_IRQ-1:0] clrPend;
    logic [NUM_IRQ-1:0] levelMode;
    logic [NUM_IRQ-1:0] levelHit;
  } irqStrobe_t;
endpackage

// File: rtl/extIrqCondition.sv
module extIrqCondition
  import extIrqPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LOG2    = 4,
  parameter int FILT_CH     = 3,
  parameter int LEVEL_CAP   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_IRQ-1:0]   pinIn,
  input  logic                 filtSlow,
  output logic [LEVEL_CAP-1:0] lvlLow,
  output logic [NUM_IRQ-1:0]   rise,
  output logic [NUM_IRQ-1:0]   fall
);
  logic [NUM_IRQ-1:0]  syncOut;
  logic [NUM_IRQ-1:0]  lvl;
  logic [NUM_IRQ-1:0]  lvlPrev;
  logic [DIV_LOG2-1:0] divCnt;
  logic                tick;

  // sample-rate prescaler for the filtered input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end
  assign tick = filtSlow ? (&divCnt) : 1'b1;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : gCh
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], pinIn[i]};
    end
    assign syncOut[i] = chain[SYNC_STAGES-1];

    if (i == FILT_CH) begin : gFilt
      logic smp;
      logic held;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          smp  <= 1'b0;
          held <= 1'b0;
        end else if (tick) begin
          smp <= syncOut[i];
          if (syncOut[i] == smp) held <= syncOut[i];
        end
      end
      assign lvl[i] = held;

      // filtered level moves only on a sample tick
      assert_filt_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
        (held != $past(held)) |-> $past(tick));
      // filtered level moves only when two samples agreed
      assert_filt_agree_R7: assert property (@(posedge clk) disable iff (!rstN)
        (held != $past(held)) |-> ($past(syncOut[i]) == $past(smp)));
    end else begin : gRaw
      assign lvl[i] = syncOut[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lvlPrev <= '0;
    else       lvlPrev <= lvl;
  end

  assign rise   = lvl & ~lvlPrev;
  assign fall   = ~lvl & lvlPrev;
  assign lvlLow = lvl[LEVEL_CAP-1:0];
endmodule

// File: rtl/extIrqControl.sv
module extIrqControl
  import extIrqPkg::*;
#(
  parameter int LEVEL_CAP = 2
) (
  input  logic [LEVEL_CAP-1:0]         lvlLow,
  input  logic [NUM_IRQ-1:0]           rise,
  input  logic [NUM_IRQ-1:0]           fall,
  input  logic [2*NUM_IRQ-1:0]         modeCfg,
  input  logic [NUM_IRQ-1:0]           enable,
  input  logic [NUM_IRQ-1:0]           ack,
  output irqStrobe_t                   strb,
  output logic [NUM_IRQ-LEVEL_CAP-1:0] tmrEvent
);
  logic [NUM_IRQ-1:0] hit;
  logic [NUM_IRQ-1:0] lvlMode;
  logic [NUM_IRQ-1:0] lvlHit;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : gDec
    irqMode_e mode;
    assign mode = irqMode_e'(modeCfg[2*i+1 -: 2]);

    if (i < LEVEL_CAP) begin : gLevelCap
      assign lvlMode[i] = (mode == MODE_HIGH) || (mode == MODE_LOW);
      assign hit[i]     = (mode == MODE_RISE) ? rise[i] :
                          (mode == MODE_FALL) ? fall[i] : 1'b0;
      assign lvlHit[i]  = (mode == MODE_HIGH) ? lvlLow[i] :
                          (mode == MODE_LOW)  ? ~lvlLow[i] : 1'b0;
    end else begin : gBothCap
      assign lvlMode[i] = 1'b0;
      assign lvlHit[i]  = 1'b0;
      assign hit[i]     = mode[1] ? (rise[i] | fall[i]) :
                          mode[0] ? fall[i] : rise[i];
    end
  end

  assign strb.setPend   = hit & enable;
  assign strb.clrPend   = ack & ~lvlMode;
  assign strb.levelMode = lvlMode;
  assign strb.levelHit  = lvlHit;
  assign tmrEvent       = hit[NUM_IRQ-1:LEVEL_CAP];
endmodule

// File: rtl/extIrqDatapath.sv
module extIrqDatapath
  import extIrqPkg::*;
#(
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  parameter int VEC_W    = 8,
  localparam int ID_W    = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobe_t         strb,
  input  logic [NUM_IRQ-1:0] enable,
  output logic [NUM_IRQ-1:0] pend,
  output logic               irqReq,
  output logic [ID_W-1:0]    irqId,
  output logic [VEC_W-1:0]   irqVector
);
  logic [NUM_IRQ-1:0] active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= '0;
    end else begin
      for (int k = 0; k < NUM_IRQ; k++) begin
        if (strb.levelMode[k])    pend[k] <= strb.levelHit[k] & enable[k];
        else if (strb.setPend[k]) pend[k] <= 1'b1;
        else if (strb.clrPend[k]) pend[k] <= 1'b0;
      end
    end
  end

  assign active = pend & enable;

  always_comb begin
    irqReq = 1'b0;
    irqId  = '0;
    for (int k = NUM_IRQ - 1; k >= 0; k--) begin
      if (active[k]) begin
        irqReq = 1'b1;
        irqId  = ID_W'(k);
      end
    end
  end

  assign irqVector = irqReq ? VEC_W'(VEC_BASE + VEC_STEP * int'(irqId)) : '0;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : gChk
    assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
      (pend[k] && !strb.levelMode[k] && !strb.clrPend[k]) |=> pend[k]);
    assert_ack_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.levelMode[k] && strb.clrPend[k] && !strb.setPend[k]) |=> !pend[k]);
  end

  assert_grant_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (pend[irqId] && enable[irqId]));
  assert_priority_R2: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((pend & enable & ((NUM_IRQ'(1) << irqId) - NUM_IRQ'(1))) == '0));
endmodule

// File: rtl/extIrqSense.sv
module extIrqSense
  import extIrqPkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int FILT_DIV_LOG2 = 4,
  parameter int VEC_BASE      = 3,
  parameter int VEC_STEP      = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] pinIn,
  input  logic [7:0] modeCfg,
  input  logic       filtSlow,
  input  logic [3:0] enable,
  input  logic [3:0] ack,
  output logic       irqReq,
  output logic [1:0] irqId,
  output logic [7:0] irqVector,
  output logic [3:0] pendFlags,
  output logic [1:0] tmrEvent
);
  localparam int LEVEL_CAP = 2;
  localparam int FILT_CH   = NUM_IRQ - 1;

  logic [LEVEL_CAP-1:0] lvlLow;
  logic [NUM_IRQ-1:0]   rise;
  logic [NUM_IRQ-1:0]   fall;
  irqStrobe_t           strb;

  extIrqCondition #(
    .SYNC_STAGES(SYNC_STAGES),
    .DIV_LOG2   (FILT_DIV_LOG2),
    .FILT_CH    (FILT_CH),
    .LEVEL_CAP  (LEVEL_CAP)
  ) condI (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .filtSlow(filtSlow),
    .lvlLow  (lvlLow),
    .rise    (rise),
    .fall    (fall)
  );

  extIrqControl #(
    .LEVEL_CAP(LEVEL_CAP)
  ) ctrlI (
    .lvlLow  (lvlLow),
    .rise    (rise),
    .fall    (fall),
    .modeCfg (modeCfg),
    .enable  (enable),
    .ack     (ack),
    .strb    (strb),
    .tmrEvent(tmrEvent)
  );

  extIrqDatapath #(
    .VEC_BASE(VEC_BASE),
    .VEC_STEP(VEC_STEP),
    .VEC_W   (8)
  ) dpI (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .enable   (enable),
    .pend     (pendFlags),
    .irqReq   (irqReq),
    .irqId    (irqId),
    .irqVector(irqVector)
  );
endmodule

// File: tb/extIrqSense_tb.sv
`timescale 1ns/1ps
module extIrqSense_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] pinIn = '0;
  logic [7:0] modeCfg = '0;
  logic       filtSlow = 1'b0;
  logic [3:0] enable = '0;
  logic [3:0] ack = '0;
  logic       irqReq;
  logic [1:0] irqId;
  logic [7:0] irqVector;
  logic [3:0] pendFlags;
  logic [1:0] tmrEvent;

  int checks = 0;
  int fails = 0;
  int evCnt2 = 0;
  int evCnt3 = 0;
  bit wdFired = 1'b0;

  always #4 clk = ~clk;

  extIrqSense dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .modeCfg(modeCfg), .filtSlow(filtSlow),
    .enable(enable), .ack(ack), .irqReq(irqReq), .irqId(irqId), .irqVector(irqVector),
    .pendFlags(pendFlags), .tmrEvent(tmrEvent)
  );

  always @(negedge clk) begin
    if (tmrEvent[0]) evCnt2 <= evCnt2 + 1;
    if (tmrEvent[1]) evCnt3 <= evCnt3 + 1;
  end

  // entry: [31:24] mode, [23:20] enable, [19:16] pin A, [15:12] pin B,
  //        [11:8] expected pending, [7:0] expected vector
  localparam logic [31:0] VEC_TAB [0:12] = '{
    32'h00F0FF03, 32'h00FF0000, 32'h55FF0F03, 32'h55F06000,
    32'hA0F0CC13, 32'hA0FC0C13, 32'h0AF0220B, 32'h0AF30000,
    32'h0FF3120B, 32'h0060F60B, 32'h0080881B, 32'h0040F413,
    32'h00F09903
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseAck(input logic [3:0] m);
    ack = m;
    step(1);
    ack = '0;
  endtask

  task automatic runTests();
    int base2;
    int base3;
    step(3);
    rstN = 1'b1;
    step(2);
    chk("R10 reset pend", 32'(pendFlags), 32'h0);
    chk("R10 reset req", 32'(irqReq), 32'h0);
    chk("R10 reset vector", 32'(irqVector), 32'h0);
    chk("R10 reset tmrEvent", 32'(tmrEvent), 32'h0);

    // table walk: R1 R3 R4 R5 R6
    for (int e = 0; e < 13; e++) begin
      modeCfg = VEC_TAB[e][31:24];
      enable  = VEC_TAB[e][23:20];
      pinIn   = VEC_TAB[e][19:16];
      step(12);
      pulseAck(4'hF);
      step(2);
      pinIn = VEC_TAB[e][15:12];
      step(12);
      chk($sformatf("R3 R4 R5 R6 table %0d pend", e), 32'(pendFlags & enable), 32'(VEC_TAB[e][11:8]));
      chk($sformatf("R1 table %0d vector", e), 32'(irqVector), 32'(VEC_TAB[e][7:0]));
      chk($sformatf("R6 table %0d req", e), 32'(irqReq), 32'(VEC_TAB[e][11:8] != 4'h0));
    end

    // priority walk R2 and vectors R1
    modeCfg = 8'h00; enable = 4'hF; pinIn = 4'h0;
    step(12); pulseAck(4'hF); step(2);
    pinIn = 4'hF; step(12);
    chk("R2 all pending vector", 32'(irqVector), 32'h03);
    chk("R1 id input 0", 32'(irqId), 32'h0);
    pulseAck(4'h1); step(2);
    chk("R2 after ack0 vector", 32'(irqVector), 32'h0B);
    pulseAck(4'h2); step(2);
    chk("R2 after ack1 vector", 32'(irqVector), 32'h13);
    pulseAck(4'h4); step(2);
    chk("R2 after ack2 vector", 32'(irqVector), 32'h1B);
    chk("R1 id input 3", 32'(irqId), 32'h3);
    pulseAck(4'h8); step(2);
    chk("R3 all acked req", 32'(irqReq), 32'h0);

    // edge flag holds R3
    pinIn = 4'h0; step(12); pulseAck(4'hF); step(2);
    pinIn = 4'h1; step(60);
    chk("R3 edge flag held", 32'(pendFlags[0]), 32'h1);
    pulseAck(4'h1); step(2);
    chk("R3 edge flag cleared", 32'(pendFlags[0]), 32'h0);

    // ack ignored in level mode R4
    modeCfg = 8'h02; step(12);
    pulseAck(4'h1); step(2);
    chk("R4 level flag ignores ack", 32'(pendFlags[0]), 32'h1);
    pinIn = 4'h0; step(8);
    chk("R4 level flag follows pin low", 32'(pendFlags[0]), 32'h0);

    // filter, fast sampling R7
    modeCfg = 8'h00; enable = 4'h8; filtSlow = 1'b0;
    step(12); pulseAck(4'hF); step(2);
    pinIn = 4'h8; step(1); pinIn = 4'h0; step(20);
    chk("R7 one-cycle pulse rejected", 32'(pendFlags[3]), 32'h0);
    pinIn = 4'h8; step(2); pinIn = 4'h0; step(20);
    chk("R7 two-cycle pulse accepted", 32'(pendFlags[3]), 32'h1);

    // filter, slow sampling R8
    pulseAck(4'hF); filtSlow = 1'b1; step(40);
    pinIn = 4'h8; step(10); pinIn = 4'h0; step(60);
    chk("R8 short pulse rejected", 32'(pendFlags[3]), 32'h0);
    pinIn = 4'h8; step(32); pinIn = 4'h0; step(60);
    chk("R8 long pulse accepted", 32'(pendFlags[3]), 32'h1);

    // timer pulses with interrupts disabled R9 R6
    pulseAck(4'hF); filtSlow = 1'b0; enable = 4'h0; modeCfg = 8'h20;
    step(20);
    base2 = evCnt2; base3 = evCnt3;
    for (int t = 0; t < 3; t++) begin
      pinIn = 4'hC; step(6);
      pinIn = 4'h0; step(6);
    end
    step(20);
    chk("R9 both-edge event count", 32'(evCnt2 - base2), 32'd6);
    chk("R9 rising event count", 32'(evCnt3 - base3), 32'd3);
    chk("R6 disabled no pending", 32'(pendFlags), 32'h0);
    chk("R6 disabled no request", 32'(irqReq), 32'h0);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (20000) @(posedge clk);
        wdFired = 1'b1;
      end
    join_any
    disable fork;
    if (wdFired) begin
      checks++;
      fails++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule